// File: doc/BRIEF.md
# PLL Setting Commit Controller with Unlock Sequence

This block is a register-bus slave that guards the settings of a clock multiplier. Software writes an enable bit, a connect bit, a multiplier value and a divider value into pending copies. The copies that actually steer the PLL, called the active settings here, change only when software completes a two-step unlock on a dedicated 8-bit key register. The first step writes 0xAA and the second writes 0x55. No other access may fall inside the protected address window between the two steps. A broken or wrong sequence leaves the active settings as they were, and the pending values wait for the next valid attempt.

The block also handles power-down requests. An accepted request switches the PLL off and disconnects it by clearing the active enable and connect bits. The pending copies are kept. Leaving power-down restores nothing, so software must run the unlock sequence again. A request is refused, and nothing changes, while the USB activity interrupt is enabled and the USB side still reports that it needs its clock.

The reset input is asynchronous and active low. Its release is synchronised inside the block, so the block leaves reset two clock edges after the input rises.

Top module: `pll_commit_ctrl`

## Requirements
- R1: After reset, the active outputs are all zero. Reads of the control, configuration, status and key registers all return zero.
- R2: Writes to the control register (bit 0 enable, bit 1 connect) and to the configuration register (bits 4:0 multiplier, bits 6:5 divider) do not change the active outputs. Reading these registers returns the written pending values.
- R3: A window access that is a key write of 0xAA, followed by the next window access being a key write of 0x55, copies every pending field to the active outputs. The copy is visible from the clock edge of the 0x55 write. Only bits 7:0 of a key write are compared.
- R4: No copy happens if the second key value is not 0x55, or if 0x55 is written without a preceding 0xAA.
- R5: Any read or write anywhere in the window between 0xAA and 0x55 voids the sequence. Idle cycles and accesses outside the window do not void it.
- R6: A second 0xAA written while the block waits for 0x55 keeps the sequence armed. A following 0x55 then copies the settings.
- R7: The key register is 8 bits wide, resets to 0x00, and reads back the last byte written to it in bits 7:0, with the upper bits zero.
- R8: An accepted power-down request clears the active enable and connect bits at the next clock edge. The active multiplier, the active divider and all pending copies keep their values.
- R9: A power-down request is refused, leaving the active outputs unchanged, only when the USB activity interrupt enable and the USB need-clock input are both 1.
- R10: After power-down the active bits stay cleared until a new valid unlock sequence copies the pending values again.
- R11: The status register returns the active settings: bit 0 enable, bit 1 connect, bits 6:2 multiplier and bits 8:7 divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_re |
| pd_req | input | 1 | Power-down request, one cycle per request |
| usb_act_irq_en | input | 1 | USB activity interrupt enabled |
| usb_clk_need | input | 1 | USB side still needs its clock |
| pll_en | output | 1 | Active enable |
| pll_conn | output | 1 | Active connect |
| pll_mul | output | 5 | Active multiplier value |
| pll_div | output | 2 | Active divider value |

## Verification
The unlock path is driven with several patterns:
- A clean 0xAA, 0x55 pair.
- A pair split by a window write, a window read, or an access outside the window.
- A wrong second byte.
- A lone 0x55.
- A doubled 0xAA.

Each pattern separates a tracker that watches only the key register from one that guards the whole window, or one that resets on a repeated first byte. Power-down is tried under each USB enable and need combination, which shows whether the refusal needs both inputs. Power-down is also followed by a re-feed, which shows that the pending copies survived while the active bits did not.

// File: rtl/pll_commit_pkg.sv
package pll_commit_pkg;

  localparam int unsigned MUL_W = 5;
  localparam int unsigned DIV_W = 2;
  localparam int unsigned KEY_W = 8;

  localparam logic [KEY_W-1:0] KEY_ARM  = 8'hAA;
  localparam logic [KEY_W-1:0] KEY_FIRE = 8'h55;

  // packed so that bit 0 is enable, as laid out in the status register
  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [MUL_W-1:0] mul;
    logic             conn;
    logic             en;
  } pll_set_t;

  localparam int unsigned SET_W = $bits(pll_set_t);

  typedef enum logic {
    FEED_IDLE  = 1'b0,
    FEED_ARMED = 1'b1
  } feed_st_t;

endpackage

// File: rtl/pll_rst_sync.sv
module pll_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pll_feed_seq.sv
module pll_feed_seq
  import pll_commit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_acc,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_byte,
  output logic             commit
);

  feed_st_t st_q;
  feed_st_t st_d;
  logic     is_arm;
  logic     is_fire;

  always_comb begin
    is_arm  = win_acc && key_wr && (key_byte == KEY_ARM);
    is_fire = win_acc && key_wr && (key_byte == KEY_FIRE);
    commit  = (st_q == FEED_ARMED) && is_fire;
    st_d    = st_q;
    if (win_acc) begin
      st_d = is_arm ? FEED_ARMED : FEED_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= FEED_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  // R6
  arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_acc && key_wr && key_byte == KEY_ARM) |=> (st_q == FEED_ARMED));

  // R5
  break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_acc && !(key_wr && key_byte == KEY_ARM)) |=> (st_q == FEED_IDLE));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_acc && st_q == FEED_IDLE) |=> (st_q == FEED_IDLE));

endmodule

// File: rtl/pll_shadow_bank.sv
module pll_shadow_bank
  import pll_commit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic             cfg_wr,
  input  logic             key_wr,
  input  logic [1:0]       ctrl_bits,
  input  logic [MUL_W-1:0] mul_in,
  input  logic [DIV_W-1:0] div_in,
  input  logic [KEY_W-1:0] key_in,
  output pll_set_t         shd,
  output logic [KEY_W-1:0] key_q
);

  pll_set_t         shd_q;
  pll_set_t         shd_d;
  logic [KEY_W-1:0] key_d;

  always_comb begin
    shd_d = shd_q;
    key_d = key_q;
    if (ctrl_wr) begin
      shd_d.en   = ctrl_bits[0];
      shd_d.conn = ctrl_bits[1];
    end
    if (cfg_wr) begin
      shd_d.mul = mul_in;
      shd_d.div = div_in;
    end
    if (key_wr) begin
      key_d = key_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q <= '0;
      key_q <= '0;
    end else begin
      shd_q <= shd_d;
      key_q <= key_d;
    end
  end

  assign shd = shd_q;

  // R2
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_wr && !cfg_wr) |=> $stable(shd_q));

endmodule

// File: rtl/pll_active_set.sv
module pll_active_set
  import pll_commit_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     commit,
  input  logic     pd_ok,
  input  pll_set_t shd,
  output pll_set_t act
);

  pll_set_t act_q;
  pll_set_t act_d;

  always_comb begin
    act_d = act_q;
    if (commit) begin
      act_d = shd;
    end
    if (pd_ok) begin
      act_d.en   = 1'b0;
      act_d.conn = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
    end else begin
      act_q <= act_d;
    end
  end

  assign act = act_q;

  // R2
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !pd_ok) |=> $stable(act_q));

  // R3
  act_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !pd_ok) |=> (act_q == $past(shd)));

  // R8
  pd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_ok |=> (!act_q.en && !act_q.conn));

  // R8
  pd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_ok && !commit) |=> ($stable(act_q.mul) && $stable(act_q.div)));

endmodule

// File: rtl/pll_commit_ctrl.sv
module pll_commit_ctrl
  import pll_commit_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       DATA_W    = 32,
  parameter logic [ADDR_W-1:0] WIN_LO    = 32'h400F_C000,
  parameter logic [ADDR_W-1:0] WIN_HI    = 32'h400F_FFFF,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 32'h400F_C020,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 32'h400F_C024,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 32'h400F_C028,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 32'h400F_C02C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              pd_req,
  input  logic              usb_act_irq_en,
  input  logic              usb_clk_need,
  output logic              pll_en,
  output logic              pll_conn,
  output logic [MUL_W-1:0]  pll_mul,
  output logic [DIV_W-1:0]  pll_div
);

  localparam int unsigned CFG_W = MUL_W + DIV_W;

  logic             rst_i_n;
  logic             in_win;
  logic             win_acc;
  logic             ctrl_wr;
  logic             cfg_wr;
  logic             key_wr;
  logic             commit;
  logic             pd_block;
  logic             pd_ok;
  logic [KEY_W-1:0] key_q;
  pll_set_t         shd;
  pll_set_t         act;
  logic [DATA_W-1:0] rd_mux;

  pll_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  always_comb begin
    in_win   = (bus_addr >= WIN_LO) && (bus_addr <= WIN_HI);
    win_acc  = in_win && (bus_we || bus_re);
    ctrl_wr  = in_win && bus_we && (bus_addr == CTRL_ADDR);
    cfg_wr   = in_win && bus_we && (bus_addr == CFG_ADDR);
    key_wr   = in_win && bus_we && (bus_addr == KEY_ADDR);
    pd_block = usb_act_irq_en && usb_clk_need;
    pd_ok    = pd_req && !pd_block;
  end

  pll_feed_seq u_feed (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .win_acc  (win_acc),
    .key_wr   (key_wr),
    .key_byte (bus_wdata[KEY_W-1:0]),
    .commit   (commit)
  );

  pll_shadow_bank u_shadow (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .ctrl_wr   (ctrl_wr),
    .cfg_wr    (cfg_wr),
    .key_wr    (key_wr),
    .ctrl_bits (bus_wdata[1:0]),
    .mul_in    (bus_wdata[MUL_W-1:0]),
    .div_in    (bus_wdata[MUL_W +: DIV_W]),
    .key_in    (bus_wdata[KEY_W-1:0]),
    .shd       (shd),
    .key_q     (key_q)
  );

  pll_active_set u_active (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .commit (commit),
    .pd_ok  (pd_ok),
    .shd    (shd),
    .act    (act)
  );

  always_comb begin
    rd_mux = '0;
    if (bus_re && in_win) begin
      if (bus_addr == CTRL_ADDR) begin
        rd_mux[1:0] = {shd.conn, shd.en};
      end else if (bus_addr == CFG_ADDR) begin
        rd_mux[CFG_W-1:0] = {shd.div, shd.mul};
      end else if (bus_addr == STAT_ADDR) begin
        rd_mux[SET_W-1:0] = act;
      end else if (bus_addr == KEY_ADDR) begin
        rd_mux[KEY_W-1:0] = key_q;
      end
    end
  end

  assign bus_rdata = rd_mux;
  assign pll_en    = act.en;
  assign pll_conn  = act.conn;
  assign pll_mul   = act.mul;
  assign pll_div   = act.div;

  // R9
  pd_refuse_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (pd_req && usb_act_irq_en && usb_clk_need && !commit)
      |=> ($stable(pll_en) && $stable(pll_conn)));

  // R10
  pd_stay_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!pll_en && !commit) |=> !pll_en);

endmodule

// File: tb/test_pll_commit_ctrl.sv
module test_pll_commit_ctrl;

  localparam int CLK_NS = 8;
  localparam logic [31:0] A_CTRL = 32'h400F_C020;
  localparam logic [31:0] A_CFG  = 32'h400F_C024;
  localparam logic [31:0] A_STAT = 32'h400F_C028;
  localparam logic [31:0] A_KEY  = 32'h400F_C02C;
  localparam logic [31:0] A_OUT  = 32'h400F_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we;
  logic        bus_re;
  logic [31:0] bus_rdata;
  logic        pd_req;
  logic        usb_act_irq_en;
  logic        usb_clk_need;
  logic        pll_en;
  logic        pll_conn;
  logic [4:0]  pll_mul;
  logic [1:0]  pll_div;

  typedef struct {
    bit          from_bus;
    logic [31:0] exp;
    string       req;
  } exp_t;

  exp_t q[$];
  int   vectors = 0;
  int   miscompares = 0;
  bit   done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  pll_commit_ctrl i_pll_commit_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_addr       (bus_addr),
    .bus_wdata      (bus_wdata),
    .bus_we         (bus_we),
    .bus_re         (bus_re),
    .bus_rdata      (bus_rdata),
    .pd_req         (pd_req),
    .usb_act_irq_en (usb_act_irq_en),
    .usb_clk_need   (usb_clk_need),
    .pll_en         (pll_en),
    .pll_conn       (pll_conn),
    .pll_mul        (pll_mul),
    .pll_div        (pll_div)
  );

  // monitor: samples 2 ns after each falling edge
  always begin
    @(negedge clk);
    #2;
    while (q.size() > 0) begin
      exp_t it;
      logic [31:0] act;
      it  = q.pop_front();
      act = it.from_bus ? bus_rdata
                        : {23'b0, pll_div, pll_mul, pll_conn, pll_en};
      vectors++;
      if (act !== it.exp) begin
        miscompares++;
        $display("FAIL %s: %s actual=0x%08h expected=0x%08h",
                 it.req, it.from_bus ? "read" : "outputs", act, it.exp);
      end
    end
  end

  task automatic step(input logic we, input logic re, input logic [31:0] a,
                      input logic [31:0] d, input logic pd);
    @(negedge clk);
    bus_we    = we;
    bus_re    = re;
    bus_addr  = a;
    bus_wdata = d;
    pd_req    = pd;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    step(1'b1, 1'b0, a, d, 1'b0);
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 32'h0, 32'h0, 1'b0);
  endtask

  task automatic chk_out(input logic [31:0] v, input string req);
    idle();
    q.push_back('{1'b0, v, req});
  endtask

  task automatic rd(input logic [31:0] a, input logic [31:0] v, input string req);
    step(1'b0, 1'b1, a, 32'h0, 1'b0);
    q.push_back('{1'b1, v, req});
  endtask

  task automatic pd_pulse();
    step(1'b0, 1'b0, 32'h0, 32'h0, 1'b1);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    bus_we = 1'b0; bus_re = 1'b0; bus_addr = '0; bus_wdata = '0;
    pd_req = 1'b0; usb_act_irq_en = 1'b0; usb_clk_need = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) idle();

    // R1 reset state
    chk_out(32'h0, "R1");
    rd(A_CTRL, 32'h0, "R1");
    rd(A_CFG,  32'h0, "R1");
    rd(A_STAT, 32'h0, "R1");
    rd(A_KEY,  32'h0, "R7");

    // R2 pending writes leave the outputs alone
    wr(A_CTRL, 32'h3);
    wr(A_CFG,  32'h53);          // mul 0x13, div 2
    chk_out(32'h0, "R2");
    rd(A_CTRL, 32'h3,  "R2");
    rd(A_CFG,  32'h53, "R2");
    rd(A_STAT, 32'h0,  "R11");

    // R3 clean unlock
    wr(A_KEY, 32'hAA);
    wr(A_KEY, 32'h55);
    chk_out(32'h14F, "R3");
    rd(A_STAT, 32'h14F, "R11");
    rd(A_KEY,  32'h55,  "R7");

    // R5 window write in between voids the sequence
    wr(A_CFG, 32'h27);           // mul 7, div 1
    wr(A_KEY, 32'hAA);
    wr(A_CTRL, 32'h3);
    wr(A_KEY, 32'h55);
    chk_out(32'h14F, "R5");

    // R5 window read in between voids the sequence
    wr(A_KEY, 32'hAA);
    rd(A_CFG, 32'h27, "R2");
    wr(A_KEY, 32'h55);
    chk_out(32'h14F, "R5");

    // R5 access outside the window and idle cycles do not void it
    wr(A_KEY, 32'hAA);
    wr(A_OUT, 32'h1234);
    idle();
    wr(A_KEY, 32'h55);
    chk_out(32'h09F, "R5");

    // R4 wrong second byte, then lone 0x55
    wr(A_CFG, 32'h01);           // mul 1, div 0
    wr(A_KEY, 32'hAA);
    wr(A_KEY, 32'h56);
    chk_out(32'h09F, "R4");
    wr(A_KEY, 32'h55);
    chk_out(32'h09F, "R4");

    // R6 doubled first byte stays armed; upper data bits ignored (R3)
    wr(A_KEY, 32'hAA);
    wr(A_KEY, 32'hAA);
    wr(A_KEY, 32'hFF00_0055);
    chk_out(32'h007, "R6");
    rd(A_KEY, 32'h55, "R7");

    // R9 refused power-down
    usb_act_irq_en = 1'b1;
    usb_clk_need   = 1'b1;
    pd_pulse();
    chk_out(32'h007, "R9");

    // R8 accepted power-down, pending copies kept
    usb_clk_need = 1'b0;
    pd_pulse();
    chk_out(32'h004, "R8");
    rd(A_CTRL, 32'h3,  "R8");
    rd(A_CFG,  32'h01, "R8");

    // R10 stays off until a new unlock
    repeat (4) idle();
    chk_out(32'h004, "R10");
    wr(A_KEY, 32'hAA);
    wr(A_KEY, 32'h55);
    chk_out(32'h007, "R10");

    // R9 need-clock alone does not refuse
    usb_act_irq_en = 1'b0;
    usb_clk_need   = 1'b1;
    pd_pulse();
    chk_out(32'h004, "R9");

    // R3 enable without connect
    wr(A_CTRL, 32'h1);
    wr(A_KEY, 32'hAA);
    wr(A_KEY, 32'h55);
    chk_out(32'h005, "R3");
    rd(A_STAT, 32'h005, "R11");

    repeat (3) idle();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule